// File: doc/BRIEF.md
# Control Transfer Classifier

This block looks at one instruction word and tells downstream logic what kind of control transfer it is. It recognises the 32-bit jump-and-link and jump-and-link-register encodings, and the four 16-bit jump forms: plain jump, jump-and-link, jump-register and jump-and-link-register. Each compressed form is judged by the full-length instruction it stands for. A separate input says whether the word holds a 16-bit instruction in its low half or a full 32-bit instruction.

The result is one of five mutually exclusive class flags: direct call, indirect call, return, indirect jump and plain direct jump. Anything else leaves every flag low. Two hints, push and pop, come with the class so that a return-address stack or a shadow-stack checker can act on them directly. Whether a transfer is a return or a call that also pops depends on whether the registers involved are one of the two conventional link registers. Those two register numbers are parameters, with defaults 1 and 5. The block is purely combinational and holds no state.

Top module: `ctc_classifier`

## Requirements
- R1: A 32-bit jump-and-link (opcode bits [6:0] = 1101111) with destination register (bits [11:7]) not zero is a direct call and raises push but not pop.
- R2: A 32-bit jump-and-link with destination zero, and the 16-bit plain jump (bits [15:13] = 101, bits [1:0] = 01), are direct jumps with neither push nor pop.
- R3: A 32-bit jump-and-link-register (opcode 1100111, bits [14:12] = 000) with destination not zero is an indirect call. It raises push, and it raises pop as well only when both the destination and the source (bits [19:15]) are link registers.
- R4: A 32-bit jump-and-link-register with destination zero and a source of 1 or 5 is a return and raises pop only.
- R5: A 32-bit jump-and-link-register with destination zero and any other source is an indirect jump with neither push nor pop.
- R6: The 16-bit jump-and-link (bits [15:13] = 001, bits [1:0] = 01) links into register 1, so it is a direct call with push only.
- R7: The 16-bit jump-and-link-register (bits [15:12] = 1001, bits [6:2] = 0, bits [11:7] = source, not zero) is always an indirect call with push. It also raises pop when the source is 1 or 5.
- R8: The 16-bit jump-register (bits [15:12] = 1000, bits [6:2] = 0, source not zero) is a return with pop when the source is 1 or 5, and otherwise an indirect jump.
- R9: Every other word gives all flags and hints low. This includes a jump-and-link-register with a nonzero function field, 16-bit register forms with source zero or bits [6:2] not zero, and a word whose bits [1:0] do not match the stated length.
- R10: At most one class flag is high at a time. Push is high only for a call, and pop only for a return or an indirect call.
- R11: When the compressed input is high, bits [31:16] of the word have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word; a 16-bit instruction sits in bits [15:0] |
| is_compressed_i | input | 1 | High when the word holds a 16-bit instruction |
| direct_call_o | output | 1 | Direct call |
| indirect_call_o | output | 1 | Indirect call |
| return_o | output | 1 | Return |
| indirect_jump_o | output | 1 | Indirect jump that is not a return |
| direct_jump_o | output | 1 | Direct jump without link |
| push_o | output | 1 | Return stack should push |
| pop_o | output | 1 | Return stack should pop |

## Verification
The hardest outcome to reach is an indirect call that raises both push and pop. It needs a destination and a source that are both link registers, and a random stream hits that pair only rarely. The bench reaches it by sweeping the full destination-by-source grid of the 32-bit register jump and every source of the 16-bit register forms. The other bits of the word are filled with random values on each pass. The reserved and breakpoint code points next to the 16-bit register jumps, and words whose length bits do not match, are driven on purpose to show that they stay unclassified.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

  localparam int REG_W   = 5;
  localparam int INSTR_W = 32;

  typedef enum logic [2:0] {
    FORM_NONE,
    FORM_JAL,
    FORM_JALR,
    FORM_CJ,
    FORM_CJAL,
    FORM_CJR,
    FORM_CJALR
  } form_e;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_DCALL,
    CLS_ICALL,
    CLS_RET,
    CLS_IJMP,
    CLS_DJMP
  } cls_e;

  typedef struct packed {
    form_e            form;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rs1;
  } jfields_t;

  function automatic logic is_link_reg(input logic [REG_W-1:0] r,
                                       input logic [REG_W-1:0] la,
                                       input logic [REG_W-1:0] lb);
    return (r == la) || (r == lb);
  endfunction

  function automatic logic is_register_target(input form_e f);
    return (f == FORM_JALR) || (f == FORM_CJR) || (f == FORM_CJALR);
  endfunction

  function automatic logic is_pc_relative(input form_e f);
    return (f == FORM_JAL) || (f == FORM_CJ) || (f == FORM_CJAL);
  endfunction

endpackage

// File: rtl/ctc_decode.sv
module ctc_decode
  import ctc_pkg::*;
#(
  parameter bit HAS_CJAL = 1'b1
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               is_compressed_i,
  output jfields_t           fields_o
);

  localparam logic [6:0]       OPC_JAL  = 7'b1101111;
  localparam logic [6:0]       OPC_JALR = 7'b1100111;
  localparam logic [REG_W-1:0] REG_RA   = REG_W'(1);

  logic [15:0] half;
  assign half = instr_i[15:0];

  // 16-bit forms, each as its own event wire
  logic cj_hit, cjal_hit, creg_shape, cjr_hit, cjalr_hit;
  assign cj_hit     = (half[15:13] == 3'b101) && (half[1:0] == 2'b01);
  assign creg_shape = (half[15:13] == 3'b100) && (half[1:0] == 2'b10) &&
                      (half[6:2] == 5'd0) && (half[11:7] != 5'd0);
  assign cjr_hit    = creg_shape && !half[12];
  assign cjalr_hit  = creg_shape &&  half[12];

  generate
    if (HAS_CJAL) begin : g_cjal
      assign cjal_hit = (half[15:13] == 3'b001) && (half[1:0] == 2'b01);
    end else begin : g_no_cjal
      assign cjal_hit = 1'b0;
    end
  endgenerate

  // 32-bit forms
  logic jal_hit, jalr_hit;
  assign jal_hit  = (instr_i[6:0] == OPC_JAL);
  assign jalr_hit = (instr_i[6:0] == OPC_JALR) && (instr_i[14:12] == 3'b000);

  logic unused_upper;
  assign unused_upper = ^instr_i[31:20];

  always_comb begin
    fields_o = '{form: FORM_NONE, rd: '0, rs1: '0};
    if (is_compressed_i) begin
      if (cj_hit) begin
        fields_o.form = FORM_CJ;
      end else if (cjal_hit) begin
        fields_o.form = FORM_CJAL;
        fields_o.rd   = REG_RA;
      end else if (cjr_hit) begin
        fields_o.form = FORM_CJR;
        fields_o.rs1  = half[11:7];
      end else if (cjalr_hit) begin
        fields_o.form = FORM_CJALR;
        fields_o.rd   = REG_RA;
        fields_o.rs1  = half[11:7];
      end
    end else if (jal_hit) begin
      fields_o.form = FORM_JAL;
      fields_o.rd   = instr_i[11:7];
    end else if (jalr_hit) begin
      fields_o.form = FORM_JALR;
      fields_o.rd   = instr_i[11:7];
      fields_o.rs1  = instr_i[19:15];
    end
  end

  always_comb begin
    if (!$isunknown({instr_i, is_compressed_i})) begin
      AST_C_FORMS_EXCLUSIVE: assert ($onehot0({cj_hit, cjal_hit, cjr_hit, cjalr_hit})) // R9
        else $error("compressed jump forms overlap");
      AST_CREG_NONZERO_SRC: assert (!(fields_o.form inside {FORM_CJR, FORM_CJALR}) || fields_o.rs1 != '0) // R8
        else $error("16-bit register jump decoded with source zero");
    end
  end

endmodule

// File: rtl/ctc_resolve.sv
module ctc_resolve
  import ctc_pkg::*;
#(
  parameter logic [REG_W-1:0] LINK_A = 5'd1,
  parameter logic [REG_W-1:0] LINK_B = 5'd5
) (
  input  jfields_t fields_i,
  output cls_e     cls_o,
  output logic     rd_link_o,
  output logic     rs1_link_o
);

  logic links_rd;
  assign rd_link_o  = is_link_reg(fields_i.rd,  LINK_A, LINK_B);
  assign rs1_link_o = is_link_reg(fields_i.rs1, LINK_A, LINK_B);
  assign links_rd   = (fields_i.rd != '0);

  always_comb begin
    cls_o = CLS_NONE;
    if (is_pc_relative(fields_i.form)) begin
      cls_o = links_rd ? CLS_DCALL : CLS_DJMP;
    end else if (is_register_target(fields_i.form)) begin
      if (links_rd)        cls_o = CLS_ICALL;
      else if (rs1_link_o) cls_o = CLS_RET;
      else                 cls_o = CLS_IJMP;
    end
  end

  always_comb begin
    if (!$isunknown(fields_i)) begin
      AST_RET_NEEDS_LINK_SRC: assert (cls_o != CLS_RET || rs1_link_o) // R4
        else $error("return without link source");
      AST_NONE_STAYS_NONE: assert (fields_i.form != FORM_NONE || cls_o == CLS_NONE) // R9
        else $error("non-jump classified");
      AST_CJALR_IS_CALL: assert (fields_i.form != FORM_CJALR || cls_o == CLS_ICALL) // R7
        else $error("16-bit link-register jump not an indirect call");
    end
  end

endmodule

// File: rtl/ctc_hint.sv
module ctc_hint
  import ctc_pkg::*;
(
  input  cls_e cls_i,
  input  logic rd_link_i,
  input  logic rs1_link_i,
  output logic push_o,
  output logic pop_o
);

  logic is_call, coroutine_swap;
  assign is_call        = (cls_i == CLS_DCALL) || (cls_i == CLS_ICALL);
  assign coroutine_swap = (cls_i == CLS_ICALL) && rd_link_i && rs1_link_i;

  assign push_o = is_call;
  assign pop_o  = (cls_i == CLS_RET) || coroutine_swap;

  always_comb begin
    if (!$isunknown({cls_i, rd_link_i, rs1_link_i})) begin
      AST_DJMP_QUIET: assert (cls_i != CLS_DJMP || (!push_o && !pop_o)) // R2
        else $error("direct jump raised a hint");
      AST_DCALL_PUSH_ONLY: assert (cls_i != CLS_DCALL || (push_o && !pop_o)) // R1
        else $error("direct call hint mismatch");
    end
  end

endmodule

// File: rtl/ctc_classifier.sv
module ctc_classifier
  import ctc_pkg::*;
#(
  parameter bit               HAS_CJAL = 1'b1,
  parameter logic [REG_W-1:0] LINK_A   = 5'd1,
  parameter logic [REG_W-1:0] LINK_B   = 5'd5
) (
  input  logic [31:0] instr_i,
  input  logic        is_compressed_i,
  output logic        direct_call_o,
  output logic        indirect_call_o,
  output logic        return_o,
  output logic        indirect_jump_o,
  output logic        direct_jump_o,
  output logic        push_o,
  output logic        pop_o
);

  jfields_t fields;
  cls_e     cls;
  logic     rd_link, rs1_link;

  ctc_decode #(.HAS_CJAL(HAS_CJAL)) i_decode (
    .instr_i         (instr_i),
    .is_compressed_i (is_compressed_i),
    .fields_o        (fields)
  );

  ctc_resolve #(.LINK_A(LINK_A), .LINK_B(LINK_B)) i_resolve (
    .fields_i   (fields),
    .cls_o      (cls),
    .rd_link_o  (rd_link),
    .rs1_link_o (rs1_link)
  );

  ctc_hint i_hint (
    .cls_i      (cls),
    .rd_link_i  (rd_link),
    .rs1_link_i (rs1_link),
    .push_o     (push_o),
    .pop_o      (pop_o)
  );

  assign direct_call_o   = (cls == CLS_DCALL);
  assign indirect_call_o = (cls == CLS_ICALL);
  assign return_o        = (cls == CLS_RET);
  assign indirect_jump_o = (cls == CLS_IJMP);
  assign direct_jump_o   = (cls == CLS_DJMP);

  always_comb begin
    if (!$isunknown({instr_i, is_compressed_i})) begin
      AST_ONE_CLASS: assert ($onehot0({direct_call_o, indirect_call_o, return_o,
                                       indirect_jump_o, direct_jump_o})) // R10
        else $error("more than one class flag");
      AST_PUSH_FROM_CALL: assert (!push_o || direct_call_o || indirect_call_o) // R10
        else $error("push without call");
      AST_POP_SOURCE: assert (!pop_o || return_o || indirect_call_o) // R10
        else $error("pop without return or indirect call");
      AST_IJMP_QUIET: assert (!indirect_jump_o || (!push_o && !pop_o)) // R5
        else $error("indirect jump raised a hint");
      AST_ICALL_PUSH: assert (!indirect_call_o || push_o) // R3
        else $error("indirect call without push");
    end
  end

endmodule

// File: tb/test_ctc_classifier.sv
module test_ctc_classifier;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] instr = '0;
  logic        is_c  = 1'b0;
  logic dcall, icall, ret, ijmp, djmp, push, pop;

  ctc_classifier i_ctc_classifier (
    .instr_i         (instr),
    .is_compressed_i (is_c),
    .direct_call_o   (dcall),
    .indirect_call_o (icall),
    .return_o        (ret),
    .indirect_jump_o (ijmp),
    .direct_jump_o   (djmp),
    .push_o          (push),
    .pop_o           (pop)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // expected vector order: {dcall, icall, ret, ijmp, djmp, push, pop}
  function automatic logic [6:0] exp_pcrel(input int rd);
    return (rd != 0) ? 7'b1000010 : 7'b0000100;
  endfunction

  function automatic logic [6:0] exp_reg(input int rd, input int rs1);
    bit src_link = (rs1 == 1) || (rs1 == 5);
    bit dst_link = (rd == 1) || (rd == 5);
    if (rd != 0) return {5'b01000, 1'b1, src_link && dst_link};
    if (src_link) return 7'b0010001;
    return 7'b0001000;
  endfunction

  task automatic apply(input bit c, input logic [31:0] w, input logic [6:0] exp,
                       input string req);
    @(posedge clk);
    is_c  <= c;
    instr <= w;
    @(negedge clk);
    checks++;
    if ({dcall, icall, ret, ijmp, djmp, push, pop} !== exp) begin
      errors++;
      $display("FAIL %s: word=%h c=%0b got=%b expected=%b", req, w, c,
               {dcall, icall, ret, ijmp, djmp, push, pop}, exp);
    end
  endtask

  function automatic logic [31:0] enc_jal(input int rd);
    return {$urandom() % 32'h100000, 5'(rd), 7'b1101111} ;
  endfunction

  function automatic logic [31:0] enc_jalr(input int rd, input int rs1, input int f3);
    return {12'($urandom()), 5'(rs1), 3'(f3), 5'(rd), 7'b1100111};
  endfunction

  function automatic logic [31:0] enc_c(input logic [15:0] h);
    return {16'($urandom()), h};
  endfunction

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset/idle state: an all-zero word is no jump (R9)
    @(negedge clk);
    checks++;
    if ({dcall, icall, ret, ijmp, djmp, push, pop} !== 7'b0) begin
      errors++;
      $display("FAIL R9 idle: got=%b expected=0000000", {dcall, icall, ret, ijmp, djmp, push, pop});
    end

    // R1, R2: 32-bit jump-and-link across destinations
    for (int rd = 0; rd < 32; rd++)
      for (int k = 0; k < 2; k++)
        apply(1'b0, enc_jal(rd), exp_pcrel(rd), rd == 0 ? "R2" : "R1");

    // R3, R4, R5: full grid of the 32-bit register jump
    for (int rd = 0; rd < 32; rd++)
      for (int rs1 = 0; rs1 < 32; rs1++)
        apply(1'b0, enc_jalr(rd, rs1, 0), exp_reg(rd, rs1),
              rd != 0 ? "R3" : ((rs1 == 1 || rs1 == 5) ? "R4" : "R5"));

    // R9: nonzero function field is not a jump
    for (int f3 = 1; f3 < 8; f3++)
      for (int rs1 = 0; rs1 < 8; rs1++)
        apply(1'b0, enc_jalr(1, rs1, f3), 7'b0, "R9");

    // R2, R6 with random upper halves (R11)
    for (int k = 0; k < 16; k++) begin
      apply(1'b1, enc_c({3'b101, 11'($urandom()), 2'b01}), exp_pcrel(0), "R2");
      apply(1'b1, enc_c({3'b001, 11'($urandom()), 2'b01}), exp_pcrel(1), "R6");
    end

    // R7, R8: every source of the 16-bit register jumps; R11 random upper half
    for (int rs1 = 1; rs1 < 32; rs1++)
      for (int k = 0; k < 2; k++) begin
        apply(1'b1, enc_c({4'b1001, 5'(rs1), 5'd0, 2'b10}), exp_reg(1, rs1), "R7");
        apply(1'b1, enc_c({4'b1000, 5'(rs1), 5'd0, 2'b10}), exp_reg(0, rs1), "R8");
      end

    // R9: reserved / breakpoint / move-style neighbours
    apply(1'b1, enc_c({4'b1000, 5'd0, 5'd0, 2'b10}), 7'b0, "R9");
    apply(1'b1, enc_c({4'b1001, 5'd0, 5'd0, 2'b10}), 7'b0, "R9");
    for (int rs2 = 1; rs2 < 32; rs2++) begin
      apply(1'b1, enc_c({4'b1000, 5'd1, 5'(rs2), 2'b10}), 7'b0, "R9");
      apply(1'b1, enc_c({4'b1001, 5'd5, 5'(rs2), 2'b10}), 7'b0, "R9");
    end
    // R9: length bits mismatch in both directions
    apply(1'b1, {16'h0000, 16'h00EF}, 7'b0, "R9");
    apply(1'b1, {16'h0000, 16'h80E7}, 7'b0, "R9");
    apply(1'b0, {16'h0000, 16'hA001}, 7'b0, "R9");
    apply(1'b0, {16'h0000, 16'h8082}, 7'b0, "R9");
    apply(1'b0, 32'h00000013, 7'b0, "R9");

    // R11: same 16-bit return with the upper half forced to look like a call
    apply(1'b1, {16'h00EF, 4'b1000, 5'd1, 5'd0, 2'b10}, 7'b0010001, "R11");
    apply(1'b1, {16'hFFFF, 4'b1000, 5'd7, 5'd0, 2'b10}, 7'b0001000, "R11");

    // R10 is covered by every vector above being at most one-hot
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule